// File: doc/BRIEF.md
# Privilege-Filtered Dual Event Counter

This block keeps two independent event counters. One 32-bit control word sets up both. For each counter the word holds a 6-bit source select, a 3-bit mode code and a monitor-pin flag. Every cycle the block receives:

- a vector of event lines,
- the current 2-bit privilege level,
- a global clock enable.

Each counter does one of two things. It counts new occurrences of its selected line, or it counts the cycles during which that line is high. In both cases counting happens only at the privilege levels its mode code permits.

Each counter drives a monitor pin through a fixed three-register delay. The pin pulses either on every increment or only on a wrap past the maximum value. A small register port gives software three things:

- the control word, written and read as one unit;
- preset and read access to each counter at any time;
- a read-only view of the sticky wrap flags.

To move a counter to a new source, software stops it through its mode code and then presets it.

Top module: `priv_evt_counter`

## Requirements
- R1: Control word layout. Counter A uses bits [5:0] for the source select, [8:6] for the mode code and [9] for the pin flag. Counter B uses bits [21:16], [24:22] and [25] for the same fields. All other bits ignore writes and read as zero, so writing all ones reads back 0x03FF03FF.
- R2: Privilege gating. Mode bit 0 enables counting at privilege levels 0, 1 and 2, and mode bit 1 enables counting at level 3. The codes 000 and 100 never count.
- R3: Occurrence mode (mode bit 2 = 0). The counter adds one in each enabled cycle where the selected line is 1 and was 0 in the previous enabled cycle.
- R4: Duration mode (mode bit 2 = 1). The counter adds one in every enabled cycle where the selected line is 1.
- R5: With `cnt_en` low, neither counter changes, and the previous-line history used by occurrence mode is held.
- R6: An increment at the all-ones value wraps the counter to zero and sets that counter's wrap flag. The flag stays set until that counter is written.
- R7: Writes take effect at the next clock edge. Address 1 presets counter A and address 2 presets counter B. A preset clears that counter's wrap flag and takes priority over an increment in the same cycle. Address 0 writes the whole control word, which governs counting from the following cycle.
- R8: Monitor pin timing. With the pin flag at 0, `mon_pin[k]` pulses high for one cycle per increment. With the flag at 1, it pulses only on a wrap. In both cases the pulse appears three cycles after the cycle in which the increment happened.
- R9: After reset, the control word, both counters and both wrap flags are zero, and both pins are low.
- R10: Reads are combinational and available while counting. Address 0 returns the control word, addresses 1 and 2 return the counters, and address 3 returns the wrap flags (bit 0 for A, bit 1 for B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Global counting enable |
| evt_in | input | 64 | Event lines, indexed by source select |
| priv_lvl | input | 2 | Current privilege level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W (40) | Write data |
| reg_rdata | output | DATA_W (40) | Read data |
| mon_pin | output | 2 | Monitor pins, bit 0 for counter A |

## Verification
The bench builds the block with an 8-bit counter width, which makes `DATA_W` 32. This puts a counter wrap a few cycles away from a preset of 254, so the wrap flag, its clearing and the overflow-only pin pulse can all be reached directly. A long random phase also wraps counters many times while presets, control rewrites, privilege changes and enable gaps are mixed in. The output is compared against a behavioural model in every cycle.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int SEL_W    = 6;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int CTRL_W   = 32;
  localparam int SLOT_OFS = 16;
  localparam int PIN_LAT  = 3;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h03FF_03FF;

  // Field order matches the per-counter slot of the control word.
  typedef struct packed {
    logic             pin_ovf;
    logic [2:0]       mode;
    logic [SEL_W-1:0] sel;
  } pec_cfg_t;

  localparam int CFG_W = $bits(pec_cfg_t);

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNTA = 2'd1,
    ADDR_CNTB = 2'd2,
    ADDR_FLAG = 2'd3
  } pec_addr_e;
endpackage

// File: rtl/pec_ctrl_reg.sv
module pec_ctrl_reg
  import pec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output pec_cfg_t          cfg [2]
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar k = 0; k < 2; k++) begin : g_slot
    assign cfg[k] = pec_cfg_t'(ctrl_q[k*SLOT_OFS +: CFG_W]);
  end

  // R1: bits outside the two slots stay zero after any write.
  p_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_q & ~CTRL_MASK) == '0));
endmodule

// File: rtl/pec_counter.sv
module pec_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         priv_lvl,
  input  pec_cfg_t           cfg,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf_q,
  output logic               pin_src
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q, prev_d;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             line, gate, hit, inc, at_max, wrap;

  always_comb begin
    line   = evt_in[cfg.sel];
    gate   = (priv_lvl == 2'd3) ? cfg.mode[1] : cfg.mode[0];
    hit    = cfg.mode[2] ? line : (line & ~prev_q);
    inc    = cnt_en & gate & hit & ~wr_en;
    at_max = (cnt_q == CNT_MAX);
    wrap   = inc & at_max;
  end

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    prev_d = prev_q;
    if (cnt_en) prev_d = line;
    if (wr_en) begin
      cnt_d = wdata;
      ovf_d = 1'b0;
    end else if (inc) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      if (wrap) ovf_d = 1'b1;
    end
  end

  assign pin_src = cfg.pin_ovf ? wrap : inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      prev_q <= prev_d;
    end
  end

  p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wdata)) && !ovf_q);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_max) |=> (cnt_q == '0) && ovf_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !wr_en) |=> ovf_q);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> $stable(cnt_q) && $stable(prev_q));
  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.mode[1:0] == 2'b00) && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/pec_pin_pipe.sv
module pec_pin_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = stg_q;
    stg_d[0] = din;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/priv_evt_counter.sv
module priv_evt_counter
  import pec_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int DATA_W = (CNT_W > 32) ? CNT_W : 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [63:0]        evt_in,
  input  logic [1:0]         priv_lvl,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [1:0]         mon_pin
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q;
  pec_cfg_t          cfg [2];
  logic [CNT_W-1:0]  cnt [2];
  logic [1:0]        ovf;
  logic [1:0]        src;
  logic              ctrl_wr;
  logic [1:0]        cnt_wr;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ctrl_wr   = reg_we && (reg_addr == ADDR_CTRL);
  assign cnt_wr[0] = reg_we && (reg_addr == ADDR_CNTA);
  assign cnt_wr[1] = reg_we && (reg_addr == ADDR_CNTB);

  pec_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (ctrl_wr),
    .wdata  (reg_wdata[CTRL_W-1:0]),
    .ctrl_q (ctrl_q),
    .cfg    (cfg)
  );

  for (genvar k = 0; k < 2; k++) begin : g_chan
    pec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cnt_en   (cnt_en),
      .evt_in   (evt_in),
      .priv_lvl (priv_lvl),
      .cfg      (cfg[k]),
      .wr_en    (cnt_wr[k]),
      .wdata    (reg_wdata[CNT_W-1:0]),
      .cnt_q    (cnt[k]),
      .ovf_q    (ovf[k]),
      .pin_src  (src[k])
    );
    pec_pin_pipe #(.DEPTH(PIN_LAT)) u_pin (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (src[k]),
      .dout  (mon_pin[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = DATA_W'(ctrl_q);
      ADDR_CNTA: reg_rdata = DATA_W'(cnt[0]);
      ADDR_CNTB: reg_rdata = DATA_W'(cnt[1]);
      ADDR_FLAG: reg_rdata = DATA_W'(ovf);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/priv_evt_counter_tb.sv
`timescale 1ns/1ps
module priv_evt_counter_tb;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam longint unsigned MAXV = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cnt_en = 1'b1;
  logic [63:0]       evt_in = '0;
  logic [1:0]        priv_lvl = '0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [1:0]        mon_pin;

  int tests = 0, fails = 0, pin1_hits = 0;
  bit done = 0, cmp_en = 0;

  always #5 clk = ~clk;

  priv_evt_counter #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_in(evt_in),
    .priv_lvl(priv_lvl), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_pin(mon_pin)
  );

  // Behavioural reference model.
  longint unsigned mcnt [2];
  bit        mprev [2];
  bit        movf  [2];
  bit [31:0] mctrl;
  bit        mq [2][$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctrl = 0;
      for (int k = 0; k < 2; k++) begin
        mcnt[k] = 0; mprev[k] = 0; movf[k] = 0;
        mq[k] = '{0, 0, 0};
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int sel; bit [2:0] md; bit pf, line, gate, inc, wr, ovp, pulse;
        sel  = int'(mctrl[16*k +: 6]);
        md   = mctrl[16*k+6 +: 3];
        pf   = mctrl[16*k+9];
        line = evt_in[sel];
        gate = (priv_lvl == 2'd3) ? md[1] : md[0];
        wr   = reg_we && (reg_addr == 2'(k + 1));
        inc  = cnt_en && gate && (md[2] ? line : (line && !mprev[k])) && !wr;
        ovp  = 0;
        if (wr) begin
          mcnt[k] = longint'(reg_wdata) & MAXV; movf[k] = 0;
        end else if (inc) begin
          if (mcnt[k] == MAXV) begin mcnt[k] = 0; movf[k] = 1; ovp = 1; end
          else mcnt[k] = mcnt[k] + 1;
        end
        if (cnt_en) mprev[k] = line;
        pulse = pf ? ovp : inc;
        void'(mq[k].pop_front());
        mq[k].push_back(pulse);
      end
      if (reg_we && reg_addr == 2'd0) mctrl = reg_wdata & 32'h03FF_03FF;
    end
  end

  task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic longint unsigned model_rd(input logic [1:0] a);
    case (a)
      2'd0: return longint'(mctrl);
      2'd1: return mcnt[0];
      2'd2: return mcnt[1];
      default: return longint'({movf[1], movf[0]});
    endcase
  endfunction

  // Per-cycle comparison, away from the active edge.
  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      chk("R8 pin A", mon_pin[0], mq[0][0]);
      chk("R8 pin B", mon_pin[1], mq[1][0]);
      chk("R10 read", reg_rdata, model_rd(reg_addr));
    end
  end

  always @(negedge clk) if (mon_pin[1]) pin1_hits++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input longint unsigned exp, input string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] cw(input int sa, input int ma, input bit pa,
                                     input int sb, input int mb, input bit pb);
    return 32'(sa) | (32'(ma) << 6) | (32'(pa) << 9) |
           (32'(sb) << 16) | (32'(mb) << 22) | (32'(pb) << 25);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    step(2);
    for (int a = 0; a < 4; a++) rd(2'(a), 0, "R9 reset read");
    chk("R9 reset pins", mon_pin, 0);
    @(negedge clk); rst_n = 1;
    step(4);
    cmp_en = 1;

    // R3/R4: occurrence on A, duration on B, both on line 5
    wr(2'd0, cw(5, 3'b011, 0, 5, 3'b111, 1));
    begin
      bit pat [8] = '{1, 1, 0, 1, 0, 0, 1, 1};
      for (int i = 0; i < 8; i++) begin evt_in[5] = pat[i]; step(1); end
    end
    evt_in = '0; step(1);
    rd(2'd1, 3, "R3 occurrence count");
    rd(2'd2, 5, "R4 duration count");

    // R2: privilege gating
    wr(2'd1, 0); wr(2'd2, 0);
    wr(2'd0, cw(7, 3'b101, 0, 7, 3'b110, 0));
    evt_in[7] = 1;
    priv_lvl = 3; step(4);
    priv_lvl = 1; step(3);
    evt_in = '0; priv_lvl = 0; step(1);
    rd(2'd1, 3, "R2 low-level counter");
    rd(2'd2, 4, "R2 level-3 counter");

    // R2: disabled codes 100 and 000
    wr(2'd0, cw(7, 3'b100, 0, 7, 3'b000, 0));
    evt_in[7] = 1;
    priv_lvl = 0; step(3); priv_lvl = 3; step(3);
    evt_in = '0; step(1);
    rd(2'd1, 3, "R2 code 100 idle");
    rd(2'd2, 4, "R2 code 000 idle");

    // R5: enable low holds counters
    wr(2'd0, cw(7, 3'b111, 0, 7, 3'b111, 0));
    cnt_en = 0; evt_in[7] = 1; step(5);
    rd(2'd1, 3, "R5 hold A");
    rd(2'd2, 4, "R5 hold B");
    cnt_en = 1; step(2); evt_in = '0; step(1);
    rd(2'd1, 5, "R5 resume A");
    rd(2'd2, 6, "R5 resume B");

    // R6/R8: wrap with overflow-only pin on B
    wr(2'd2, 254);
    wr(2'd0, cw(7, 3'b111, 0, 7, 3'b111, 1));
    pin1_hits = 0;
    evt_in[7] = 1; step(3); evt_in = '0; step(6);
    rd(2'd2, 1, "R6 wrap value");
    rd(2'd1, 8, "R6 no wrap on A");
    rd(2'd3, 2, "R6 sticky flag B");
    chk("R8 one overflow pulse", pin1_hits, 1);
    step(3);
    rd(2'd3, 2, "R6 flag still set");

    // R7: preset wins over increment and clears flag
    evt_in[7] = 1;
    wr(2'd2, 10);
    rd(2'd2, 10, "R7 preset value");
    rd(2'd3, 0, "R7 flag cleared");
    evt_in = '0; step(1);

    // R1: reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h03FF_03FF, "R1 reserved read zero");
    wr(2'd0, 0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      evt_in   = {$urandom, $urandom};
      priv_lvl = 2'($urandom);
      cnt_en   = ($urandom_range(0, 9) != 0);
      reg_addr = 2'($urandom);
      if (r < 3)       begin reg_we = 1; reg_addr = 0; reg_wdata = $urandom; end
      else if (r < 6)  begin reg_we = 1; reg_addr = 2'($urandom_range(1, 2));
                             reg_wdata = $urandom_range(240, 255); end
      else             reg_we = 0;
      step(1);
    end
    reg_we = 0;
    step(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule